// File: doc/BRIEF.md
# Complex Reference Code Loader

This block holds a frequency-domain reference code for a correlation engine. Software streams the code in over a simple word-addressed register bus, one complex sample per write to the load register. An internal store index picks the entry, starting at zero and stepping by one after every accepted store. A write to the rewind register brings the index back to zero so that a new code can be loaded over the old one.

Each entry is a 20-bit packed word made of two signed 10-bit components. The correlation engine reads entries by index through a separate read port with one cycle of latency and gets both components sign-extended to the output width. The number of valid entries is a power of two taken from a length-exponent input. Once that many entries have been stored, more load writes are dropped until the index is rewound, so a loader that runs past the end cannot overwrite the start of the code.

Top module: `refcode_loader`

## Requirements
- R1: After a synchronous reset, both read outputs are zero and the first accepted store goes to entry 0.
- R2: A bus write to word index 6 stores one entry at the current store index, and the index then advances by one, so consecutive stores fill entries 0, 1, 2 and so on in order.
- R3: A stored entry keeps bits 19:0 of the bus data: bits 9:0 are the real component and bits 19:10 are the imaginary component. Bits 31:20 are discarded.
- R4: When `rd_en` is high at a clock edge, the entry at `rd_addr` appears on `rd_real` and `rd_imag` after that edge, each component sign-extended from bit 9. While `rd_en` is low, both outputs hold their values.
- R5: A bus write to word index 9 sets the store index back to zero, whatever its data, so the next store overwrites entry 0.
- R6: After 2^`len_log2` entries have been stored since the last rewind or reset, further writes to word index 6 change no entry until a rewind.
- R7: A `len_log2` above log2 of the depth is treated as the full depth, and the index never goes beyond the depth.
- R8: Bus writes to any word index other than 6 and 9 change neither the entries nor the store index.
- R9: While `bus_we` is low, the bus word and data have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_word | input | 4 | Word index of the bus write |
| bus_wdata | input | 32 | Bus write data |
| len_log2 | input | 4 | Exponent of the number of valid entries |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Entry index to read |
| rd_real | output | 16 | Sign-extended real component |
| rd_imag | output | 16 | Sign-extended imaginary component |

## Verification
The bench overruns the configured length and reads back entry 0 and its neighbours. A loader that wrapped would show the overrun data there instead of the first samples. It loads components at both extremes of the 10-bit range, with junk in the discarded upper bits, so a swapped field, a missing sign extension or leaked upper bits shows up as a wrong output value. It also checks the rewind in the middle of a load, writes to unrelated word indices, idle strobes and an out-of-range length exponent. A design that stepped on a stray write or failed to clamp would leave later entries at the wrong index.

// File: rtl/refcode_pkg.sv
// Shared constants for the reference code loader.
// Assumes a word-addressed register bus where only the word index matters.
package refcode_pkg;
    // Word index whose write stores one complex entry
    localparam int unsigned WORD_LOAD   = 6;
    // Word index whose write rewinds the store index
    localparam int unsigned WORD_REWIND = 9;
endpackage

// File: rtl/refcode_ctrl.sv
// Store-index control: decodes bus writes, keeps the store index,
// and blocks stores once the configured number of entries is loaded.
// Assumes at most one bus write per cycle.
module refcode_ctrl #(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned WORD_W  = 4,
    parameter int unsigned BUS_W   = 32,
    parameter int unsigned ENTRY_W = 20,
    parameter int unsigned AW      = $clog2(DEPTH),
    parameter int unsigned LW      = $clog2(AW + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [WORD_W-1:0]  bus_word,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [LW-1:0]      len_log2,
    output logic               mem_we,
    output logic [AW-1:0]      mem_waddr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic [AW:0]        store_cnt,
    output logic               load_full
);
    import refcode_pkg::*;

    logic [LW-1:0] len_eff;
    logic [AW:0]   limit;
    logic          hit_load;
    logic          hit_rewind;

    // Clamp the length exponent to the memory depth and form the entry limit
    always_comb begin
        len_eff = (int'(len_log2) > int'(AW)) ? LW'(AW) : len_log2;
        limit   = (AW+1)'(1) << len_eff;
    end

    // Decode the word index of a bus write
    always_comb begin
        hit_load   = bus_we && (bus_word == WORD_W'(WORD_LOAD));
        hit_rewind = bus_we && (bus_word == WORD_W'(WORD_REWIND));
    end

    assign load_full = (store_cnt >= limit);
    assign mem_we    = hit_load && !load_full;
    assign mem_waddr = store_cnt[AW-1:0];
    assign mem_wdata = bus_wdata[ENTRY_W-1:0];

    // Store index: reset, rewind, or advance after an accepted store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_cnt <= '0;
        end else if (hit_rewind) begin
            store_cnt <= '0;
        end else if (mem_we) begin
            store_cnt <= store_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/refcode_mem.sv
// Simple dual-port storage for packed complex entries.
// One write port, one registered read port; a read of the entry being
// written in the same cycle returns the old contents.
module refcode_mem #(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned ENTRY_W = 20,
    parameter int unsigned AW      = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic               re,
    input  logic [AW-1:0]      raddr,
    output logic [ENTRY_W-1:0] rdata
);
    logic [ENTRY_W-1:0] store [DEPTH];

    // Write one entry
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Registered read, cleared by reset, held while no read is requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/refcode_unpack.sv
// Splits a packed entry into its real (low) and imaginary (high) fields
// and sign-extends each to the output width. Assumes OUT_W >= COMP_W.
module refcode_unpack #(
    parameter int unsigned COMP_W  = 10,
    parameter int unsigned OUT_W   = 16,
    parameter int unsigned ENTRY_W = 2 * COMP_W
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic [OUT_W-1:0]   re_out,
    output logic [OUT_W-1:0]   im_out
);
    logic [COMP_W-1:0] re_f;
    logic [COMP_W-1:0] im_f;

    assign re_f = entry[COMP_W-1:0];
    assign im_f = entry[2*COMP_W-1:COMP_W];

    generate
        if (OUT_W > COMP_W) begin : g_ext
            // Replicate the sign bit of each field
            assign re_out = {{(OUT_W-COMP_W){re_f[COMP_W-1]}}, re_f};
            assign im_out = {{(OUT_W-COMP_W){im_f[COMP_W-1]}}, im_f};
        end else begin : g_same
            assign re_out = re_f;
            assign im_out = im_f;
        end
    endgenerate
endmodule

// File: rtl/refcode_loader.sv
// Reference code loader top: bus-driven sequential fill of a complex
// entry memory plus a one-cycle read port for the correlation engine.
// Assumes the bus presents one write per cycle and that the reader does
// not read an entry in the cycle it is being stored.
module refcode_loader #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned COMP_W = 10,
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned WORD_W = 4,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned AW     = $clog2(DEPTH),
    parameter int unsigned LW     = $clog2(AW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [LW-1:0]     len_log2,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [OUT_W-1:0]  rd_real,
    output logic [OUT_W-1:0]  rd_imag
);
    localparam int unsigned ENTRY_W = 2 * COMP_W;

    logic               mem_we;
    logic [AW-1:0]      mem_waddr;
    logic [ENTRY_W-1:0] mem_wdata;
    logic [ENTRY_W-1:0] mem_rdata;
    logic [AW:0]        store_cnt;
    logic               load_full;

    refcode_ctrl #(
        .DEPTH(DEPTH), .WORD_W(WORD_W), .BUS_W(BUS_W),
        .ENTRY_W(ENTRY_W), .AW(AW), .LW(LW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .len_log2(len_log2), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .store_cnt(store_cnt), .load_full(load_full)
    );

    refcode_mem #(
        .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .AW(AW)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .re(rd_en), .raddr(rd_addr), .rdata(mem_rdata)
    );

    refcode_unpack #(
        .COMP_W(COMP_W), .OUT_W(OUT_W), .ENTRY_W(ENTRY_W)
    ) u_unpack (
        .entry(mem_rdata), .re_out(rd_real), .im_out(rd_imag)
    );
endmodule

// File: rtl/refcode_loader_chk.sv
// Protocol checks for the reference code loader, bound to the top.
module refcode_loader_chk #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned WORD_W = 4,
    parameter int unsigned AW     = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [WORD_W-1:0] bus_word,
    input logic              rd_en,
    input logic [OUT_W-1:0]  rd_real,
    input logic [OUT_W-1:0]  rd_imag,
    input logic [AW:0]       store_cnt,
    input logic              load_full
);
    import refcode_pkg::*;

    logic is_rewind;
    logic is_load;
    assign is_rewind = bus_we && (bus_word == WORD_W'(WORD_REWIND));
    assign is_load   = bus_we && (bus_word == WORD_W'(WORD_LOAD));

    // R1
    reset_index_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> store_cnt == '0);

    // R5
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rewind |=> store_cnt == '0);

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && !load_full) |=> store_cnt == $past(store_cnt) + 1'b1);

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_full && !is_rewind) |=> $stable(store_cnt));

    // R7
    index_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_cnt <= (AW+1)'(DEPTH));

    // R4
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_real) && $stable(rd_imag)));
endmodule

bind refcode_loader refcode_loader_chk #(
    .DEPTH(DEPTH), .OUT_W(OUT_W), .WORD_W(WORD_W), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_word(bus_word),
    .rd_en(rd_en), .rd_real(rd_real), .rd_imag(rd_imag),
    .store_cnt(store_cnt), .load_full(load_full)
);

// File: tb/refcode_loader_test.sv
module refcode_loader_test;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  len_log2 = 4'd4;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_real;
    logic [15:0] rd_imag;

    int n_checks = 0;
    int n_fail   = 0;
    logic [19:0] model [DEPTH];

    always #2.5 clk = ~clk;

    refcode_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .len_log2(len_log2), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_real(rd_real), .rd_imag(rd_imag)
    );

    function automatic logic [15:0] sext10(input logic [9:0] v);
        return {{6{v[9]}}, v};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_word = w; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic read_check(input string tag, input int a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'(a);
        @(posedge clk); #1;
        rd_en = 1'b0;
        check({tag, " re"}, rd_real, sext10(model[a][9:0]));
        check({tag, " im"}, rd_imag, sext10(model[a][19:10]));
    endtask

    task automatic load(input logic [31:0] d, input int idx);
        bus_write(4'd6, d);
        model[idx] = d[19:0];
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] r;
        logic [15:0] h_re, h_im;
        r = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs zero after reset
        check("R1 reset re", rd_real, 16'h0);
        check("R1 reset im", rd_imag, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3: 16-entry load with junk in the upper bits, extremes first
        len_log2 = 4'd4;
        load(32'hFFF0_0200 | (32'h1FF << 10), 0);
        load(32'hA5A0_0000 | (32'h200 << 10) | 32'h1FF, 1);
        for (int i = 2; i < 16; i++) load($urandom, i);
        for (int i = 0; i < 16; i++) read_check("R2 R3 fill", i);
        for (int k = 0; k < 20; k++) read_check("R4 random read", int'($urandom_range(0, 15)));

        // R6: overrun must not touch entry 0..2
        bus_write(4'd6, 32'h000A_BCDE);
        bus_write(4'd6, 32'h0001_2345);
        bus_write(4'd6, 32'h0005_4321);
        read_check("R6 entry0 kept", 0);
        read_check("R6 entry1 kept", 1);
        read_check("R6 entry2 kept", 2);

        // R4: outputs hold while rd_en is low
        read_check("R4 latency", 5);
        h_re = rd_real; h_im = rd_imag;
        @(negedge clk); rd_addr = 8'd6;
        @(posedge clk); #1;
        check("R4 hold re", rd_real, h_re);
        check("R4 hold im", rd_imag, h_im);

        // R5 R8 R9: rewind, stray word, idle strobe
        bus_write(4'd9, 32'hFFFF_FFFF);
        bus_write(4'd7, 32'h000F_0F0F);
        bus_write(4'd3, 32'h0003_3333);
        @(negedge clk);
        bus_we = 1'b0; bus_word = 4'd6; bus_wdata = 32'h0007_7777;
        @(posedge clk); #1;
        load(32'h0001_1111, 0);
        load(32'h0002_2222, 1);
        read_check("R5 rewind entry0", 0);
        read_check("R8 R9 entry1 next", 1);
        read_check("R8 entry2 untouched", 2);

        // R5: rewind mid-load restarts at entry 0
        bus_write(4'd9, 32'h0);
        load(32'h0003_3003, 0);
        read_check("R5 mid-load rewind", 0);
        read_check("R5 entry1 kept", 1);

        // R7: out-of-range exponent clamps to depth
        len_log2 = 4'd15;
        bus_write(4'd9, 32'h0);
        for (int i = 0; i < DEPTH; i++) load($urandom, i);
        bus_write(4'd6, 32'h000C_0FFE);
        read_check("R7 entry0 after depth", 0);
        read_check("R7 last entry", DEPTH - 1);
        for (int k = 0; k < 16; k++) read_check("R7 random", int'($urandom_range(0, DEPTH - 1)));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule